// File: doc/BRIEF.md
# Counter Overflow Request Enable Controller

This block turns overflow events from three event counters and one cycle counter into two level request outputs: a debug request meant for an external debugger, and an interrupt request. Every overflow pulse sets a sticky flag for its counter. Each request kind has its own per-counter enable bits. A request output is high when any counter has both its flag and its enable for that kind set.

Software controls the enables through a small register bus. Each request kind has one set address and one clear address. Writing a one to a bit at the set address turns that counter's enable on. Writing a one to the same bit at the clear address turns it off. A zero bit at either address changes nothing. A read of either address returns the enables as they are now. Privileged accesses always take effect. A user-mode access takes effect only while the user-access enable input is high; otherwise it is dropped.

The flags are cleared through a separate write-one-to-clear input mask driven by the logic that owns the counters.

Top module: `ovf_req_ctrl`

## Requirements
- R1: A synchronous active-high reset clears all enables, all overflow flags, both request outputs and the read data to zero.
- R2: Bus word layout: bit 31 is the cycle counter, bits 2, 1 and 0 are event counters 2, 1 and 0. Address map: 0 is debug set, 1 is debug clear, 2 is interrupt set, 3 is interrupt clear. Addresses 4 to 7 read as zero, and writes to them have no effect.
- R3: A write to a set address turns on each enable whose bit is 1. Enables whose bit is 0 keep their value.
- R4: A write to a clear address turns off each enable whose bit is 1. Enables whose bit is 0 keep their value. Set writes never turn an enable off.
- R5: Reading the set address or the clear address of a path returns that path's current enables in the R2 layout. The data appears on bus_rdata one cycle after the address is presented. Bits 30 to 3 always read as zero, and their write values are ignored.
- R6: An overflow pulse sets that counter's sticky flag. A flag is cleared only by a 1 on the matching ovf_clr bit, where bit 3 is the cycle counter and bits 2 to 0 are the event counters. If a pulse and a clear hit the same flag in the same cycle, the pulse wins.
- R7: dbg_req is high one cycle after any counter has both its flag and its debug enable set, and low one cycle after no counter does.
- R8: irq_req follows the same rule as R7 using the interrupt enables. The interrupt enables are fully independent of the debug enables.
- R9: An access is permitted when bus_priv is high, or when usr_en is high. A write that is not permitted leaves all enables unchanged. A read that is not permitted returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_priv | input | 1 | High for a privileged access |
| usr_en | input | 1 | Allows user-mode accesses when high |
| bus_rdata | output | 32 | Registered read data |
| ovf_evt | input | 3 | Overflow pulses from the event counters |
| ovf_cyc | input | 1 | Overflow pulse from the cycle counter |
| ovf_clr | input | 4 | Write-one-to-clear mask for the overflow flags |
| dbg_req | output | 1 | Level debug request |
| irq_req | output | 1 | Level interrupt request |

## Verification
Enable writes are tried with several kinds of data: a single bit, mixed bits, all zeros, and reserved bits only. Comparing the read-back across these separates correct set and clear behaviour from a plain overwrite, and shows whether the cycle-counter bit and the reserved bits are mapped correctly.

Overflows are raised on counters that are enabled and on counters that are not, and on each path in turn. This tells the flag-and-enable gating apart from a plain OR of flags, and shows whether the two paths share state. A pulse and a clear on the same flag in the same cycle checks which one wins.

Accesses are tried as privileged, as user mode with usr_en low, and as user mode with usr_en high. This separates the permission gating from the address decode.

// File: rtl/ovf_req_pkg.sv
package ovf_req_pkg;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 3;
  localparam int NUM_EVT  = 3;
  localparam int NUM_CNT  = NUM_EVT + 1;
  localparam int CYC_BIT  = DATA_W - 1;
  localparam int NUM_PATH = 2;
  localparam int PATH_DBG = 0;
  localparam int PATH_IRQ = 1;

  typedef logic [NUM_CNT-1:0] cnt_mask_t;

  // Bus word to per-counter mask: low bits are event counters, top bit is cycle counter
  function automatic cnt_mask_t word_to_mask(logic [DATA_W-1:0] w);
    cnt_mask_t m;
    for (int i = 0; i < NUM_EVT; i++) m[i] = w[i];
    m[NUM_EVT] = w[CYC_BIT];
    return m;
  endfunction

  function automatic logic [DATA_W-1:0] mask_to_word(cnt_mask_t m);
    logic [DATA_W-1:0] w;
    w = '0;
    for (int i = 0; i < NUM_EVT; i++) w[i] = m[i];
    w[CYC_BIT] = m[NUM_EVT];
    return w;
  endfunction
endpackage

// File: rtl/ovf_bus_decode.sv
module ovf_bus_decode
  import ovf_req_pkg::*;
(
  input  logic [ADDR_W-1:0]                 addr,
  input  logic                              wr,
  input  logic [DATA_W-1:0]                 wdata,
  input  logic                              priv,
  input  logic                              usr_en,
  output logic                              allowed,
  output logic [NUM_PATH-1:0][NUM_CNT-1:0]  set_m,
  output logic [NUM_PATH-1:0][NUM_CNT-1:0]  clr_m
);
  cnt_mask_t wmask;

  always_comb begin
    allowed = priv | usr_en;
    wmask   = word_to_mask(wdata);
    for (int p = 0; p < NUM_PATH; p++) begin
      set_m[p] = (wr && allowed && addr == ADDR_W'(2 * p))     ? wmask : '0;
      clr_m[p] = (wr && allowed && addr == ADDR_W'(2 * p + 1)) ? wmask : '0;
    end
  end
endmodule

// File: rtl/ovf_enable_bank.sv
module ovf_enable_bank #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_m,
  input  logic [N-1:0] clr_m,
  output logic [N-1:0] en_q
);
  always_ff @(posedge clk) begin
    if (rst) en_q <= '0;
    else     en_q <= (en_q | set_m) & ~clr_m;
  end
endmodule

// File: rtl/ovf_flag_bank.sv
module ovf_flag_bank #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pulse,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flag_q
);
  // A new pulse takes priority over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (rst) flag_q <= '0;
    else     flag_q <= (flag_q & ~clr) | pulse;
  end
endmodule

// File: rtl/ovf_req_merge.sv
module ovf_req_merge #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] flag_q,
  input  logic [N-1:0] en_q,
  output logic         req_q
);
  always_ff @(posedge clk) begin
    if (rst) req_q <= 1'b0;
    else     req_q <= |(flag_q & en_q);
  end
endmodule

// File: rtl/ovf_req_ctrl.sv
module ovf_req_ctrl
  import ovf_req_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic [DATA_W-1:0]  bus_wdata,
  input  logic               bus_priv,
  input  logic               usr_en,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic [NUM_EVT-1:0] ovf_evt,
  input  logic               ovf_cyc,
  input  logic [NUM_CNT-1:0] ovf_clr,
  output logic               dbg_req,
  output logic               irq_req
);
  logic                             allowed;
  logic [NUM_PATH-1:0][NUM_CNT-1:0] set_m;
  logic [NUM_PATH-1:0][NUM_CNT-1:0] clr_m;
  logic [NUM_PATH-1:0][NUM_CNT-1:0] en_q;
  logic [NUM_PATH-1:0]              req_q;
  logic [NUM_CNT-1:0]               flag_q;
  logic [DATA_W-1:0]                rd_word;

  ovf_bus_decode u_dec (
    .addr    (bus_addr),
    .wr      (bus_wr),
    .wdata   (bus_wdata),
    .priv    (bus_priv),
    .usr_en  (usr_en),
    .allowed (allowed),
    .set_m   (set_m),
    .clr_m   (clr_m)
  );

  ovf_flag_bank #(.N(NUM_CNT)) u_flags (
    .clk    (clk),
    .rst    (rst),
    .pulse  ({ovf_cyc, ovf_evt}),
    .clr    (ovf_clr),
    .flag_q (flag_q)
  );

  for (genvar p = 0; p < NUM_PATH; p++) begin : g_path
    ovf_enable_bank #(.N(NUM_CNT)) u_en (
      .clk   (clk),
      .rst   (rst),
      .set_m (set_m[p]),
      .clr_m (clr_m[p]),
      .en_q  (en_q[p])
    );
    ovf_req_merge #(.N(NUM_CNT)) u_req (
      .clk    (clk),
      .rst    (rst),
      .flag_q (flag_q),
      .en_q   (en_q[p]),
      .req_q  (req_q[p])
    );
  end

  // Both addresses of a path return the live enables; unmapped or denied reads give zero
  always_comb begin
    rd_word = '0;
    if (allowed) begin
      for (int p = 0; p < NUM_PATH; p++) begin
        if (bus_addr == ADDR_W'(2 * p) || bus_addr == ADDR_W'(2 * p + 1))
          rd_word = mask_to_word(en_q[p]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_word;
  end

  assign dbg_req = req_q[PATH_DBG];
  assign irq_req = req_q[PATH_IRQ];
endmodule

// File: rtl/ovf_req_ctrl_chk.sv
module ovf_req_ctrl_chk
  import ovf_req_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic               bus_wr,
  input logic [DATA_W-1:0]  bus_wdata,
  input logic               bus_priv,
  input logic               usr_en,
  input logic [DATA_W-1:0]  bus_rdata,
  input logic [NUM_EVT-1:0] ovf_evt,
  input logic               ovf_cyc,
  input logic [NUM_CNT-1:0] ovf_clr,
  input logic [NUM_CNT-1:0] flag_q,
  input logic [NUM_CNT-1:0] dbg_en,
  input logic [NUM_CNT-1:0] irq_en,
  input logic               dbg_req,
  input logic               irq_req
);
  logic ok_acc;
  assign ok_acc = bus_priv | usr_en;

  a_r7_dbg_high: assert property (@(posedge clk) disable iff (rst)
    (|(flag_q & dbg_en)) |=> dbg_req);
  a_r7_dbg_low: assert property (@(posedge clk) disable iff (rst)
    !(|(flag_q & dbg_en)) |=> !dbg_req);
  a_r8_irq_high: assert property (@(posedge clk) disable iff (rst)
    (|(flag_q & irq_en)) |=> irq_req);
  a_r8_irq_low: assert property (@(posedge clk) disable iff (rst)
    !(|(flag_q & irq_en)) |=> !irq_req);
  a_r3_set_cyc: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && ok_acc && bus_addr == ADDR_W'(0) && bus_wdata[CYC_BIT]) |=> dbg_en[NUM_EVT]);
  a_r4_clr_evt0: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && ok_acc && bus_addr == ADDR_W'(1) && bus_wdata[0]) |=> !dbg_en[0]);
  a_r9_deny_write: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !ok_acc) |=> ($stable(dbg_en) && $stable(irq_en)));
  a_r9_deny_read: assert property (@(posedge clk) disable iff (rst)
    !ok_acc |=> (bus_rdata == '0));
  a_r6_pulse_sets: assert property (@(posedge clk) disable iff (rst)
    (|{ovf_cyc, ovf_evt}) |=> ((flag_q & $past({ovf_cyc, ovf_evt})) == $past({ovf_cyc, ovf_evt})));
  a_r6_sticky: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((($past(flag_q) & ~$past(ovf_clr)) & ~flag_q) == '0));

  always @(negedge clk) begin
    if (!rst) a_r5_reserved_zero: assert (bus_rdata[CYC_BIT-1:NUM_EVT] == '0);
  end
endmodule

bind ovf_req_ctrl ovf_req_ctrl_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_wdata (bus_wdata),
  .bus_priv  (bus_priv),
  .usr_en    (usr_en),
  .bus_rdata (bus_rdata),
  .ovf_evt   (ovf_evt),
  .ovf_cyc   (ovf_cyc),
  .ovf_clr   (ovf_clr),
  .flag_q    (flag_q),
  .dbg_en    (en_q[ovf_req_pkg::PATH_DBG]),
  .irq_en    (en_q[ovf_req_pkg::PATH_IRQ]),
  .dbg_req   (dbg_req),
  .irq_req   (irq_req)
);

// File: tb/ovf_req_ctrl_tb.sv
module ovf_req_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_priv = 1'b1;
  logic        usr_en = 1'b0;
  logic [31:0] bus_rdata;
  logic [2:0]  ovf_evt = '0;
  logic        ovf_cyc = 1'b0;
  logic [3:0]  ovf_clr = '0;
  logic        dbg_req;
  logic        irq_req;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  ovf_req_ctrl u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_priv(bus_priv), .usr_en(usr_en),
    .bus_rdata(bus_rdata), .ovf_evt(ovf_evt), .ovf_cyc(ovf_cyc),
    .ovf_clr(ovf_clr), .dbg_req(dbg_req), .irq_req(irq_req)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d, input logic pv, input logic ue);
    bus_addr = a; bus_wdata = d; bus_priv = pv; usr_en = ue; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_priv = 1'b1; usr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic pv, input logic ue, output logic [31:0] d);
    bus_addr = a; bus_priv = pv; usr_en = ue;
    @(negedge clk);
    d = bus_rdata;
    bus_priv = 1'b1; usr_en = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic pulse(input logic [2:0] ev, input logic cy, input logic [3:0] cl);
    ovf_evt = ev; ovf_cyc = cy; ovf_clr = cl;
    @(negedge clk);
    ovf_evt = '0; ovf_cyc = 1'b0; ovf_clr = '0;
    settle();
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    do_reset();
    check("R1 dbg_req", 32'(dbg_req), 0);
    check("R1 irq_req", 32'(irq_req), 0);
    rd(3'd0, 1, 0, d); check("R1 debug enables", d, 0);
    rd(3'd2, 1, 0, d); check("R1 irq enables", d, 0);
  endtask

  task automatic t_set_clear();
    logic [31:0] d;
    wr(3'd0, 32'h8000_0005, 1, 0);
    rd(3'd0, 1, 0, d); check("R3 R2 set cycle and evt0 evt2", d, 32'h8000_0005);
    rd(3'd1, 1, 0, d); check("R5 clear address reads enables", d, 32'h8000_0005);
    wr(3'd0, 32'h0000_0002, 1, 0);
    rd(3'd0, 1, 0, d); check("R3 zero bits keep value", d, 32'h8000_0007);
    wr(3'd1, 32'h8000_0001, 1, 0);
    rd(3'd0, 1, 0, d); check("R4 clear cycle and evt0", d, 32'h0000_0006);
    wr(3'd1, 32'h0000_0000, 1, 0);
    rd(3'd0, 1, 0, d); check("R4 zero clear no effect", d, 32'h0000_0006);
    wr(3'd0, 32'h0000_0000, 1, 0);
    rd(3'd0, 1, 0, d); check("R4 zero set does not disable", d, 32'h0000_0006);
  endtask

  task automatic t_reserved();
    logic [31:0] d;
    wr(3'd0, 32'h7FFF_FFF8, 1, 0);
    rd(3'd0, 1, 0, d); check("R5 reserved write ignored", d, 32'h0000_0006);
    wr(3'd5, 32'hFFFF_FFFF, 1, 0);
    rd(3'd0, 1, 0, d); check("R2 unmapped write ignored dbg", d, 32'h0000_0006);
    rd(3'd2, 1, 0, d); check("R2 unmapped write ignored irq", d, 32'h0000_0000);
    rd(3'd5, 1, 0, d); check("R2 unmapped read zero", d, 32'h0000_0000);
  endtask

  task automatic t_irq_path();
    logic [31:0] d;
    wr(3'd2, 32'h8000_0000, 1, 0);
    rd(3'd3, 1, 0, d); check("R8 irq set cycle", d, 32'h8000_0000);
    rd(3'd0, 1, 0, d); check("R8 debug enables untouched", d, 32'h0000_0006);
  endtask

  task automatic t_requests();
    // debug enables = evt1, evt2; irq enables = cycle
    pulse(3'b001, 0, 4'h0);
    check("R7 flag without enable no dbg_req", 32'(dbg_req), 0);
    check("R8 flag without enable no irq_req", 32'(irq_req), 0);
    pulse(3'b000, 1, 4'h0);
    check("R8 cycle overflow irq_req", 32'(irq_req), 1);
    check("R7 cycle overflow no dbg_req", 32'(dbg_req), 0);
    pulse(3'b000, 0, 4'hF);
    check("R6 flags cleared irq_req low", 32'(irq_req), 0);
    pulse(3'b010, 0, 4'h0);
    check("R7 evt1 overflow dbg_req", 32'(dbg_req), 1);
    wr(3'd1, 32'h0000_0002, 1, 0); settle();
    check("R7 enable cleared dbg_req low", 32'(dbg_req), 0);
    wr(3'd0, 32'h0000_0002, 1, 0); settle();
    check("R6 flag sticky dbg_req returns", 32'(dbg_req), 1);
    pulse(3'b100, 0, 4'hF);
    check("R6 pulse wins over clear", 32'(dbg_req), 1);
    pulse(3'b000, 0, 4'h4);
    check("R6 evt1 flag was cleared", 32'(dbg_req), 0);
  endtask

  task automatic t_privilege();
    logic [31:0] d;
    wr(3'd0, 32'h0000_0001, 0, 0);
    rd(3'd0, 1, 0, d); check("R9 denied write no effect", d, 32'h0000_0006);
    rd(3'd0, 0, 0, d); check("R9 denied read zero", d, 32'h0000_0000);
    wr(3'd1, 32'h8000_0000, 0, 0);
    rd(3'd2, 1, 0, d); check("R9 denied clear no effect", d, 32'h8000_0000);
    wr(3'd0, 32'h0000_0001, 0, 1);
    rd(3'd0, 0, 1, d); check("R9 user access with enable", d, 32'h0000_0007);
  endtask

  task automatic t_reset_again();
    logic [31:0] d;
    pulse(3'b001, 0, 4'h0);
    check("R7 dbg_req before reset", 32'(dbg_req), 1);
    do_reset();
    @(negedge clk);
    check("R1 reset clears dbg_req", 32'(dbg_req), 0);
    rd(3'd0, 1, 0, d); check("R1 reset clears enables", d, 0);
    rd(3'd2, 1, 0, d); check("R1 reset clears irq enables", d, 0);
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_set_clear();
    t_reserved();
    t_irq_path();
    t_requests();
    t_privilege();
    t_reset_again();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule